// File: doc/BRIEF.md
# Serial-Programmed Converter Register Front End

This block is the digital control core of a 12-bit voltage-output converter. A host writes 16-bit frames over a three-wire serial link (active-low select, serial clock, data in). Each frame carries a 4-bit command in its leading bits and a 12-bit code after it, most significant bit first. The command is decoded when select returns high. It can fill a holding register, fill the holding and output registers together, copy holding to output, or enter and leave a low-power state. The output register code drives the converter ladder, which lies outside this block.

Three active-low side pins act without the serial link. One copies the holding register into the output register. One forces both registers to the code for zero volts, which is 000h in unipolar mode and 800h in bipolar mode. One forces the low-power state. A serial data output repeats every received bit 16.5 serial clocks later so that several parts can share one link. All serial and side pins are brought into the fast system clock domain through synchronizer chains, and edges are detected there.

Top module: `dac_serial_front`

## Requirements
- R1: After synchronous reset the output code is the zero-volt code (000h when `range_uni`=1, 800h when `range_uni`=0), `shut_flag`=0 and `dout_oe`=0.
- R2: A frame is taken as the bits sampled on rising serial clock edges while select is low. It is executed on the rise of select only if at least 16 edges were seen, and then the last 16 bits are used (bits 15:12 command, bits 11:0 code). Shorter frames have no effect.
- R3: Command 0010 writes the code to the holding register and leaves the output code unchanged.
- R4: Command 0100 writes the code to both the holding and output registers.
- R5: Command 0110 copies the holding register into the output register. Command 0000 and every command not listed in R3 to R6 change nothing.
- R6: Command 1000 sets the low-power state and 1100 clears it. Neither touches the registers, and register commands still work while in that state. Holding `sleep_n` low forces `shut_flag`=1.
- R7: Holding `load_n` low copies the holding register into the output register.
- R8: Holding `clear_n` low sets both registers to the zero-volt code of R1.
- R9: `dout` presents, on the falling serial clock edge that follows the 17th rising edge, the bit taken on the 1st rising edge (a 16.5-clock delay). Contents left over from the previous frame come out first. `dout_oe`=1 only while select is low and `shut_flag`=0.
- R10: Serial clock edges while select is high change neither the shift contents nor the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| range_uni | input | 1 | 1 selects unipolar range, 0 bipolar (static strap) |
| ser_clk | input | 1 | Serial clock |
| ser_cs_n | input | 1 | Active-low frame select |
| ser_din | input | 1 | Serial data in |
| load_n | input | 1 | Active-low holding-to-output copy |
| clear_n | input | 1 | Active-low clear to zero-volt code |
| sleep_n | input | 1 | Active-low forced low-power state |
| dac_code | output | 12 | Output register code to the converter |
| shut_flag | output | 1 | Low-power state indicator |
| dout | output | 1 | Daisy-chain serial data out |
| dout_oe | output | 1 | Drive enable for `dout` (0 means high impedance) |

## Verification
Several properties are checked on every cycle. The clear pin forces the zero code, and the load pin copies the holding value. Both registers hold whenever no frame, load or clear is present. The sleep pin always yields the low-power flag, the data-out enable never rises while select is high or the block sleeps, and a frame executes only just after select has risen. Only the bench scenarios can show the command decoding for each nibble, the discard of short frames, the use of the last 16 bits of a long frame, and the exact half-cycle-offset bit order on the daisy output. These depend on a whole serial transaction and are compared against a per-cycle reference model.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

    localparam int CMD_W = 4;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP       = 4'b0000,
        CMD_LOAD_IN   = 4'b0010,
        CMD_LOAD_BOTH = 4'b0100,
        CMD_COPY      = 4'b0110,
        CMD_SLEEP     = 4'b1000,
        CMD_WAKE      = 4'b1100
    } cmd_e;

    typedef struct packed {
        logic load_in;
        logic load_out;
        logic copy;
        logic sleep;
        logic wake;
    } act_t;

    typedef struct packed {
        logic sclk;
        logic cs_n;
        logic din;
        logic load_n;
        logic clear_n;
        logic sleep_n;
    } pins_t;

    localparam pins_t PINS_IDLE = '{sclk: 1'b0, cs_n: 1'b1, din: 1'b0,
                                    load_n: 1'b1, clear_n: 1'b1, sleep_n: 1'b1};

    function automatic act_t decode_cmd(input logic [CMD_W-1:0] c);
        act_t a;
        a = '0;
        case (c)
            CMD_LOAD_IN:   a.load_in = 1'b1;
            CMD_LOAD_BOTH: begin
                a.load_in  = 1'b1;
                a.load_out = 1'b1;
            end
            CMD_COPY:      a.copy  = 1'b1;
            CMD_SLEEP:     a.sleep = 1'b1;
            CMD_WAKE:      a.wake  = 1'b1;
            default:       a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/dsf_sync.sv
module dsf_sync #(
    parameter int            W       = 1,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= RST_VAL;
            else     chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dsf_serial_rx.sv
module dsf_serial_rx #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sclk_s,
    input  logic               cs_n_s,
    input  logic               din_s,
    output logic [FRAME_W-1:0] frame_q,
    output logic               frame_ok,
    output logic               dout
);
    localparam int               CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(FRAME_W);

    logic             sclk_p;
    logic             cs_p;
    logic             stage;
    logic [CNT_W-1:0] cnt;
    logic             rise;
    logic             fall;
    logic             cs_end;
    logic             cs_act;

    always_comb begin
        rise   = sclk_s & ~sclk_p;
        fall   = ~sclk_s & sclk_p;
        cs_end = cs_n_s & ~cs_p;
        cs_act = ~cs_n_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_p   <= 1'b0;
            cs_p     <= 1'b1;
            stage    <= 1'b0;
            cnt      <= '0;
            frame_q  <= '0;
            frame_ok <= 1'b0;
            dout     <= 1'b0;
        end else begin
            sclk_p   <= sclk_s;
            cs_p     <= cs_n_s;
            frame_ok <= 1'b0;
            if (cs_end) begin
                frame_ok <= (cnt == FULL);
                cnt      <= '0;
            end else if (cs_act && rise) begin
                frame_q <= {frame_q[FRAME_W-2:0], din_s};
                stage   <= frame_q[FRAME_W-1];
                if (cnt != FULL) cnt <= cnt + 1'b1;
            end
            if (cs_act && fall) dout <= stage;
        end
    end
endmodule

// File: rtl/dsf_regfile.sv
module dsf_regfile
    import dsf_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               range_uni,
    input  logic               clr_n_s,
    input  logic               ld_n_s,
    input  logic               slp_n_s,
    input  logic               frame_ok,
    input  logic [FRAME_W-1:0] frame_q,
    output logic [DATA_W-1:0]  inp_code,
    output logic [DATA_W-1:0]  dac_code,
    output logic               shut_flag
);
    logic [DATA_W-1:0] zc;
    logic [DATA_W-1:0] fdata;
    logic [CMD_W-1:0]  cmd;
    act_t              act;
    logic              soft_shut;

    always_comb begin
        zc    = range_uni ? '0 : {1'b1, {(DATA_W-1){1'b0}}};
        cmd   = frame_q[FRAME_W-1 -: CMD_W];
        fdata = frame_q[DATA_W-1:0];
        act   = frame_ok ? decode_cmd(cmd) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            inp_code  <= zc;
            dac_code  <= zc;
            soft_shut <= 1'b0;
        end else begin
            if (act.sleep) soft_shut <= 1'b1;
            if (act.wake)  soft_shut <= 1'b0;
            if (!clr_n_s) begin
                inp_code <= zc;
                dac_code <= zc;
            end else begin
                if (act.load_in) inp_code <= fdata;
                if (act.load_out)  dac_code <= fdata;
                else if (act.copy) dac_code <= inp_code;
                else if (!ld_n_s)  dac_code <= inp_code;
            end
        end
    end

    assign shut_flag = soft_shut | ~slp_n_s;
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
    import dsf_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              range_uni,
    input  logic              ser_clk,
    input  logic              ser_cs_n,
    input  logic              ser_din,
    input  logic              load_n,
    input  logic              clear_n,
    input  logic              sleep_n,
    output logic [DATA_W-1:0] dac_code,
    output logic              shut_flag,
    output logic              dout,
    output logic              dout_oe
);
    localparam int FRAME_W = CMD_W + DATA_W;

    pins_t              raw;
    pins_t              syn;
    logic [FRAME_W-1:0] frame_q;
    logic               frame_ok;
    logic [DATA_W-1:0]  inp_code;
    logic               cs_n_s;
    logic               clr_n_s;
    logic               ld_n_s;
    logic               slp_n_s;

    always_comb begin
        raw = '{sclk: ser_clk, cs_n: ser_cs_n, din: ser_din,
                load_n: load_n, clear_n: clear_n, sleep_n: sleep_n};
        cs_n_s  = syn.cs_n;
        clr_n_s = syn.clear_n;
        ld_n_s  = syn.load_n;
        slp_n_s = syn.sleep_n;
    end

    dsf_sync #(
        .W       ($bits(pins_t)),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (syn)
    );

    dsf_serial_rx #(
        .FRAME_W (FRAME_W)
    ) u_rx (
        .clk      (clk),
        .rst      (rst),
        .sclk_s   (syn.sclk),
        .cs_n_s   (cs_n_s),
        .din_s    (syn.din),
        .frame_q  (frame_q),
        .frame_ok (frame_ok),
        .dout     (dout)
    );

    dsf_regfile #(
        .DATA_W  (DATA_W),
        .FRAME_W (FRAME_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .range_uni (range_uni),
        .clr_n_s   (clr_n_s),
        .ld_n_s    (ld_n_s),
        .slp_n_s   (slp_n_s),
        .frame_ok  (frame_ok),
        .frame_q   (frame_q),
        .inp_code  (inp_code),
        .dac_code  (dac_code),
        .shut_flag (shut_flag)
    );

    assign dout_oe = ~cs_n_s & ~shut_flag;
endmodule

// File: rtl/dsf_checker.sv
module dsf_checker #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              range_uni,
    input logic              clr_n_s,
    input logic              ld_n_s,
    input logic              slp_n_s,
    input logic              cs_n_s,
    input logic              frame_ok,
    input logic [DATA_W-1:0] inp_code,
    input logic [DATA_W-1:0] dac_code,
    input logic              shut_flag,
    input logic              dout_oe
);
    localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};
    logic [DATA_W-1:0] zc;
    assign zc = range_uni ? '0 : MID;

    // R1
    a_r1_reset_code: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (dac_code == zc && !shut_flag));

    // R2
    a_r2_exec_after_select: assert property (@(posedge clk) disable iff (rst)
        frame_ok |-> $past(cs_n_s));

    // R5
    a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        (!frame_ok && clr_n_s && ld_n_s) |=> ($stable(dac_code) && $stable(inp_code)));

    // R6
    a_r6_pin_forces_sleep: assert property (@(posedge clk) disable iff (rst)
        !slp_n_s |-> shut_flag);

    // R7
    a_r7_load_pin_copy: assert property (@(posedge clk) disable iff (rst)
        (!ld_n_s && clr_n_s && !frame_ok) |=> (dac_code == $past(inp_code)));

    // R8
    a_r8_clear_zero: assert property (@(posedge clk) disable iff (rst)
        !clr_n_s |=> (dac_code == zc && inp_code == zc));

    // R9
    a_r9_oe_gating: assert property (@(posedge clk) disable iff (rst)
        dout_oe |-> (!cs_n_s && !shut_flag));
endmodule

bind dac_serial_front dsf_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .range_uni (range_uni),
    .clr_n_s   (clr_n_s),
    .ld_n_s    (ld_n_s),
    .slp_n_s   (slp_n_s),
    .cs_n_s    (cs_n_s),
    .frame_ok  (frame_ok),
    .inp_code  (inp_code),
    .dac_code  (dac_code),
    .shut_flag (shut_flag),
    .dout_oe   (dout_oe)
);

// File: tb/dac_serial_front_bench.sv
module dac_serial_front_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic range_uni = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_cs_n = 1'b1;
    logic ser_din = 1'b0;
    logic load_n = 1'b1;
    logic clear_n = 1'b1;
    logic sleep_n = 1'b1;
    logic [11:0] dac_code;
    logic shut_flag, dout, dout_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_serial_front u_dac_serial_front (
        .clk(clk), .rst(rst), .range_uni(range_uni),
        .ser_clk(ser_clk), .ser_cs_n(ser_cs_n), .ser_din(ser_din),
        .load_n(load_n), .clear_n(clear_n), .sleep_n(sleep_n),
        .dac_code(dac_code), .shut_flag(shut_flag), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // pin history, index 0 = newest sample; bits: 0 sclk,1 cs_n,2 din,3 load_n,4 clear_n,5 sleep_n
    localparam logic [5:0] IDLE = 6'b111010;
    logic [5:0]  h [4];
    logic [15:0] msh;
    int          mcnt;
    logic        mstage, mdout, mok, msoft;
    logic [11:0] minp, mdac;

    always @(posedge clk) begin
        logic [11:0] zc;
        logic [3:0]  c;
        bit rise, fall, act, cend;
        zc = range_uni ? 12'h000 : 12'h800;
        if (rst) begin
            for (int i = 0; i < 4; i++) h[i] = IDLE;
            msh = '0; mcnt = 0; mstage = 0; mdout = 0; mok = 0; msoft = 0;
            minp = zc; mdac = zc;
        end else begin
            h[3] = h[2]; h[2] = h[1]; h[1] = h[0];
            h[0] = {sleep_n, clear_n, load_n, ser_din, ser_cs_n, ser_clk};
            c = msh[15:12];
            if (mok && c == 4'b1000) msoft = 1;
            if (mok && c == 4'b1100) msoft = 0;
            if (!h[2][4]) begin
                minp = zc; mdac = zc;
            end else if (mok && c == 4'b0010) minp = msh[11:0];
            else if (mok && c == 4'b0100) begin minp = msh[11:0]; mdac = msh[11:0]; end
            else if (mok && c == 4'b0110) mdac = minp;
            else if (!h[2][3]) mdac = minp;
            rise = h[2][0] && !h[3][0];
            fall = !h[2][0] && h[3][0];
            act  = !h[2][1];
            cend = h[2][1] && !h[3][1];
            mok = 0;
            if (cend) begin mok = (mcnt >= 16); mcnt = 0; end
            else if (act && rise) begin
                if (fall == 0) mdout = mdout;
                mstage = msh[15];
                msh = {msh[14:0], h[2][2]};
                if (mcnt < 16) mcnt++;
            end
            if (act && fall) mdout = mstage;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R4 model output code", dac_code, mdac);
            chk("R6 model low-power flag", shut_flag, msoft | !h[1][5]);
            chk("R9 model output enable", dout_oe, !h[1][1] && !(msoft | !h[1][5]));
            chk("R9 model daisy data", dout, mdout);
        end
    end

    // ---------------- stimulus ----------------
    logic cap [40];

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input int nbits, input logic [31:0] word);
        ser_cs_n = 0;
        wclk(4);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_din = word[i];
            wclk(2);
            ser_clk = 1;
            wclk(4);
            ser_clk = 0;
            wclk(4);
            cap[nbits - 1 - i] = dout;
        end
        ser_cs_n = 1;
        wclk(8);
    endtask

    task automatic do_reset();
        rst = 1;
        wclk(3);
        rst = 0;
        wclk(1);
    endtask

    initial begin
        do_reset();
        chk("R1 bipolar reset code", dac_code, 12'h800);
        chk("R1 reset low-power flag", shut_flag, 0);
        chk("R1 reset output enable", dout_oe, 0);

        send(16, 32'h2123);
        chk("R3 input-only load keeps output", dac_code, 12'h800);
        send(16, 32'h6000);
        chk("R5 copy input to output", dac_code, 12'h123);
        send(16, 32'h4ABC);
        chk("R4 load both", dac_code, 12'hABC);
        send(16, 32'h2555);
        chk("R3 output unchanged", dac_code, 12'hABC);
        load_n = 0; wclk(4); load_n = 1; wclk(4);
        chk("R7 load pin copy", dac_code, 12'h555);

        send(15, 32'h27FF);
        chk("R2 short frame discarded", dac_code, 12'h555);
        send(16, 32'h1777);
        chk("R5 unlisted command 0001", dac_code, 12'h555);
        send(16, 32'hE777);
        chk("R5 unlisted command 1110", dac_code, 12'h555);
        send(16, 32'h0777);
        chk("R5 no-op command", dac_code, 12'h555);

        send(16, 32'h8000);
        chk("R6 enter low-power", shut_flag, 1);
        chk("R6 sleep keeps output code", dac_code, 12'h555);
        ser_cs_n = 0; wclk(4);
        chk("R9 enable off while sleeping", dout_oe, 0);
        ser_cs_n = 1; wclk(8);
        send(16, 32'h4777);
        chk("R6 programming while sleeping", dac_code, 12'h777);
        send(16, 32'hC000);
        chk("R6 leave low-power", shut_flag, 0);
        ser_cs_n = 0; wclk(4);
        chk("R9 enable on with select low", dout_oe, 1);
        ser_cs_n = 1; wclk(8);

        sleep_n = 0; wclk(4);
        chk("R6 sleep pin forces flag", shut_flag, 1);
        sleep_n = 1; wclk(4);
        chk("R6 sleep pin released", shut_flag, 0);

        ser_din = 1;
        for (int k = 0; k < 5; k++) begin
            ser_clk = 1; wclk(4); ser_clk = 0; wclk(4);
        end
        chk("R10 edges with select high", dac_code, 12'h777);
        send(16, 32'h4321);
        chk("R4 load both after idle edges", dac_code, 12'h321);
        for (int j = 0; j < 16; j++) begin
            logic [15:0] prev;
            prev = 16'hC000;
            chk("R10 daisy shows untouched previous frame", cap[j], prev[15 - j]);
        end

        send(20, 32'hF4123);
        chk("R2 long frame uses last 16 bits", dac_code, 12'h123);
        for (int j = 0; j < 20; j++) begin
            logic [15:0] prev;
            logic [19:0] w;
            prev = 16'h4321;
            w = 20'hF4123;
            if (j < 16) chk("R9 daisy delay previous bits", cap[j], prev[15 - j]);
            else        chk("R9 daisy delay own bits", cap[j], w[19 - (j - 16)]);
        end

        clear_n = 0; wclk(4); clear_n = 1; wclk(4);
        chk("R8 clear to bipolar zero", dac_code, 12'h800);
        send(16, 32'h6000);
        chk("R8 holding register cleared", dac_code, 12'h800);

        range_uni = 1;
        do_reset();
        chk("R1 unipolar reset code", dac_code, 12'h000);
        send(16, 32'h4ABC);
        chk("R4 unipolar load", dac_code, 12'hABC);
        clear_n = 0; wclk(4); clear_n = 1; wclk(4);
        chk("R8 clear to unipolar zero", dac_code, 12'h000);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule